// File: doc/BRIEF.md
# Periodic Tick Interrupt Controller

This block gathers six periodic tick pulses into one interrupt request. Each pulse marks the rollover of a time counter, for example 10 ms, 100 ms, second, minute, hour and day. Every tick sets its own sticky flag. These flags do not depend on any enable, and any access to their register clears them. Ticks that are also enabled set one summary pending flag. Only that summary flag drives the interrupt, and it stays set until software writes a one to it.

A route bit sends the pending interrupt to one of two active-low request pins: the main interrupt pin or the multifunction pin. The pin that is not selected stays high. Software reaches the block through a small synchronous register port. The port has a select, a write strobe, a two-bit address, write data and read data. Read data is combinational from the current state.

Top module: `tick_irq_top`

## Requirements
- R1: After reset, the tick flags, tick enables, route bit and pending flag are all zero, and both request pins are high.
- R2: A high bit of `tickIn` in a cycle sets the matching tick flag (address 1, bits 5:0) at that clock edge, whatever the enables are.
- R3: Any read or write with `busSel` high at address 1 clears all six tick flags at that clock edge, except the bits covered by R4.
- R4: When a tick and an access to address 1 occur in the same cycle, the ticked bits are set after the edge and no event is lost.
- R5: The enable register (address 2, bits 5:0) is written with `busWr`. The pending flag (address 0, bit 0) is set at the edge of any cycle in which a tick bit and its enable bit are both high. The enable value that applies is the one held before that edge.
- R6: Writing a one to address 0 bit 0 clears the pending flag, and writing a zero there has no effect. A pending set in the same cycle as the clear wins, so the flag stays set.
- R7: The pending flag stays set while the enables are changed or cleared, until R6 clears it.
- R8: The route bit is address 3 bit 0. While the flag is pending, route 0 drives `irqMainN` low and route 1 drives `irqAuxN` low. The pin that is not selected, and both pins when nothing is pending, stay high.
- R9: A read returns zero-extended data. Address 0 returns the pending flag, address 1 the tick flags, address 2 the enables and address 3 the route bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tickIn | input | 6 | One-cycle rollover tick pulses |
| busSel | input | 1 | Register access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Register address |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data (combinational) |
| irqMainN | output | 1 | Main interrupt request, active low |
| irqAuxN | output | 1 | Multifunction interrupt request, active low |

## Verification
The hardest cases to reach are same-cycle collisions. One is a tick landing in the cycle that reads or writes the tick-flag register. The other is an enabled tick landing in the cycle that writes one to clear the pending flag. In both cases the set must win. Directed steps create each collision on purpose. The random phase then draws ticks and register accesses independently on every cycle, so many more collisions occur under varied enable and route settings, and a bench model checks the results.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;
  localparam int NUM_TICKS = 6;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 2;

  localparam logic [ADDR_W-1:0] ADDR_STAT  = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_FLAGS = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_EN    = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_ROUTE = 2'd3;

  typedef struct packed {
    logic flagAcc;
    logic statClr;
    logic enWr;
    logic routeWr;
  } strobe_t;
endpackage

// File: rtl/tick_irq_ctrl.sv
module tick_irq_ctrl
  import tick_irq_pkg::*;
#(
  parameter int ADDR_BITS = ADDR_W,
  parameter int DATA_BITS = DATA_W
) (
  input  logic                 busSel,
  input  logic                 busWr,
  input  logic [ADDR_BITS-1:0] busAddr,
  input  logic [DATA_BITS-1:0] busWdata,
  output strobe_t              strobes
);
  logic doWrite;

  always_comb begin
    doWrite         = busSel && busWr;
    strobes.flagAcc = busSel && (busAddr == ADDR_FLAGS);
    strobes.statClr = doWrite && (busAddr == ADDR_STAT) && busWdata[0];
    strobes.enWr    = doWrite && (busAddr == ADDR_EN);
    strobes.routeWr = doWrite && (busAddr == ADDR_ROUTE);
  end
endmodule

// File: rtl/tick_irq_dp.sv
module tick_irq_dp
  import tick_irq_pkg::*;
#(
  parameter int TICKS     = NUM_TICKS,
  parameter int ADDR_BITS = ADDR_W,
  parameter int DATA_BITS = DATA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TICKS-1:0]     tickIn,
  input  strobe_t              strobes,
  input  logic [ADDR_BITS-1:0] busAddr,
  input  logic [DATA_BITS-1:0] busWdata,
  output logic [DATA_BITS-1:0] busRdata,
  output logic                 irqMainN,
  output logic                 irqAuxN
);
  localparam int PAD_W = DATA_BITS - TICKS;

  logic [TICKS-1:0] flagReg;
  logic [TICKS-1:0] enReg;
  logic             routeReg;
  logic             pendReg;
  logic             pendSet;

  assign pendSet = |(tickIn & enReg);

  // per-tick flag cells: access clears, tick set has priority
  for (genvar i = 0; i < TICKS; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            flagReg[i] <= 1'b0;
      else if (tickIn[i])    flagReg[i] <= 1'b1;
      else if (strobes.flagAcc) flagReg[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enReg    <= '0;
      routeReg <= 1'b0;
      pendReg  <= 1'b0;
    end else begin
      if (strobes.enWr)    enReg    <= busWdata[TICKS-1:0];
      if (strobes.routeWr) routeReg <= busWdata[0];
      if (pendSet)              pendReg <= 1'b1;
      else if (strobes.statClr) pendReg <= 1'b0;
    end
  end

  always_comb begin
    busRdata = '0;
    case (busAddr)
      ADDR_STAT:  busRdata[0] = pendReg;
      ADDR_FLAGS: busRdata = {{PAD_W{1'b0}}, flagReg};
      ADDR_EN:    busRdata = {{PAD_W{1'b0}}, enReg};
      default:    busRdata[0] = routeReg;
    endcase
  end

  assign irqMainN = ~(pendReg & ~routeReg);
  assign irqAuxN  = ~(pendReg & routeReg);

  // R3
  flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.flagAcc && tickIn == '0) |=> (flagReg == '0));
  // R4
  tick_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|tickIn) |=> ((flagReg & $past(tickIn)) == $past(tickIn)));
  // R6
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobes.statClr && !pendSet) |=> !pendReg);
  // R7
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pendReg && !strobes.statClr) |=> pendReg);
  // R8
  one_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pendReg |-> ($countones({irqMainN, irqAuxN}) == 1));
  // R8
  idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pendReg |-> (irqMainN && irqAuxN));
endmodule

// File: rtl/tick_irq_top.sv
module tick_irq_top
  import tick_irq_pkg::*;
#(
  parameter int TICKS     = NUM_TICKS,
  parameter int ADDR_BITS = ADDR_W,
  parameter int DATA_BITS = DATA_W
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [TICKS-1:0]     tickIn,
  input  logic                 busSel,
  input  logic                 busWr,
  input  logic [ADDR_BITS-1:0] busAddr,
  input  logic [DATA_BITS-1:0] busWdata,
  output logic [DATA_BITS-1:0] busRdata,
  output logic                 irqMainN,
  output logic                 irqAuxN
);
  strobe_t strobes;

  tick_irq_ctrl #(.ADDR_BITS(ADDR_BITS), .DATA_BITS(DATA_BITS)) u_ctrl (
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .strobes(strobes)
  );

  tick_irq_dp #(.TICKS(TICKS), .ADDR_BITS(ADDR_BITS), .DATA_BITS(DATA_BITS)) u_dp (
    .clk(clk), .rst_n(rst_n), .tickIn(tickIn), .strobes(strobes),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .irqMainN(irqMainN), .irqAuxN(irqAuxN)
  );
endmodule

// File: tb/sim_tick_irq_top.sv
`timescale 1ns/1ps
module sim_tick_irq_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [5:0] tickIn = '0;
  logic       busSel = 1'b0;
  logic       busWr = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic       irqMainN, irqAuxN;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  logic [5:0] mFlags = '0, mEn = '0;
  logic       mPend = 0, mRoute = 0;

  always #10 clk = ~clk;

  tick_irq_top u0 (.*);

  function automatic logic [7:0] expRead(input logic [1:0] a);
    case (a)
      2'd0: return {7'b0, mPend};
      2'd1: return {2'b0, mFlags};
      2'd2: return {2'b0, mEn};
      default: return {7'b0, mRoute};
    endcase
  endfunction

  function automatic logic [1:0] expPins();
    return {~(mPend & ~mRoute), ~(mPend & mRoute)};
  endfunction

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one cycle: drive at negedge, check read data, clock, update model, check pins
  task automatic step(input logic [5:0] t, input logic s, input logic w,
                      input logic [1:0] a, input logic [7:0] d, input string tag);
    logic clr;
    tickIn = t; busSel = s; busWr = w; busAddr = a; busWdata = d;
    #1;
    if (s && !w) check(tag, busRdata, expRead(a));
    @(posedge clk);
    clr = s && w && a == 2'd0 && d[0];
    mPend = (mPend & ~clr) | (|(t & mEn));
    mFlags = (s && a == 2'd1) ? t : (mFlags | t);
    if (s && w && a == 2'd2) mEn = d[5:0];
    if (s && w && a == 2'd3) mRoute = d[0];
    @(negedge clk);
    tickIn = '0; busSel = 0; busWr = 0;
    check({tag, "/R8 pins"}, {6'b0, irqMainN, irqAuxN}, {6'b0, expPins()});
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    step(6'h0, 1, 0, a, 8'h00, tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d, input string tag);
    step(6'h0, 1, 1, a, d, tag);
  endtask

  task automatic idle(input logic [5:0] t, input string tag);
    step(t, 0, 0, 2'd0, 8'h00, tag);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 pins", {6'b0, irqMainN, irqAuxN}, 8'h03);
    for (int a = 0; a < 4; a++) rd(a[1:0], "R1 reset read");
    // R2 flag set without enable
    idle(6'h08, "R2 tick");
    rd(2'd1, "R2 flag read");
    rd(2'd0, "R2 no pend");
    // R3 read cleared flags
    rd(2'd1, "R3 cleared by read");
    idle(6'h21, "R3 tick");
    wr(2'd1, 8'hFF, "R3 write access");
    rd(2'd1, "R3 cleared by write");
    // R4 tick with access
    idle(6'h10, "R4 prep");
    step(6'h02, 1, 0, 2'd1, 8'h00, "R4 read collide");
    rd(2'd1, "R4 tick kept");
    step(6'h04, 1, 1, 2'd1, 8'h00, "R4 write collide");
    rd(2'd1, "R4 tick kept on write");
    // R5 enables
    wr(2'd2, 8'hC5, "R5 enable write");
    rd(2'd2, "R9 enable read");
    idle(6'h02, "R5 disabled tick");
    rd(2'd0, "R5 not pending");
    idle(6'h04, "R5 enabled tick");
    rd(2'd0, "R5 pending");
    // R6 clear
    wr(2'd0, 8'hFE, "R6 write zero");
    rd(2'd0, "R6 still pending");
    step(6'h01, 1, 1, 2'd0, 8'h01, "R6 clear collide");
    rd(2'd0, "R6 set wins");
    wr(2'd0, 8'h01, "R6 clear");
    rd(2'd0, "R6 cleared");
    // R7 hold with enables off
    idle(6'h01, "R7 set");
    wr(2'd2, 8'h00, "R7 disable all");
    repeat (4) idle(6'h3F, "R7 idle");
    rd(2'd0, "R7 still pending");
    // R8 route
    wr(2'd3, 8'h01, "R8 route aux");
    rd(2'd3, "R9 route read");
    wr(2'd3, 8'h00, "R8 route main");
    wr(2'd0, 8'h01, "R8 clear");
    // random phase
    for (int n = 0; n < 3000; n++) begin
      logic [5:0] t;
      logic s, w;
      logic [1:0] a;
      logic [7:0] d;
      t = ($urandom_range(0, 3) == 0) ? 6'($urandom) : 6'h0;
      s = $urandom_range(0, 1);
      w = $urandom_range(0, 1);
      a = 2'($urandom);
      d = 8'($urandom);
      step(t, s, w, a, d, "R9 random");
    end
    for (int a = 0; a < 4; a++) rd(a[1:0], "R9 final read");
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule